// File: doc/BRIEF.md
# Event permission filter

This block decides which event numbers a performance-counter bank may count. It holds one permission bit per event number and serves three kinds of request, one at a time. A range command allows or denies a contiguous run of event numbers. A lookup returns whether one event number may be counted. A capability request takes a 64-bit event-capability value read from the hardware and clears every bit whose event is not permitted, so that only permitted events are advertised.

After reset the filter is unconfigured and every event is permitted. The first accepted range command fixes the default for all events it does not name. If it allows a range, every other event becomes denied. If it denies a range, every other event stays allowed. Later commands change only their own range. The permission store is a word-organised RAM that can map onto block RAM. Its size follows the event-number width, 2^EVT_W events. Each capability word takes its low half from events 32*sel to 32*sel+31 and its high half from events HI_OFS+32*sel upward.

Top module: `evt_permit_filter`

## Requirements
- R1: While unconfigured (after reset, before any accepted command), every lookup returns `lk_ok`=1 and a capability request returns `cap_raw` unchanged, apart from R11.
- R2: A command whose `cmd_base`+`cmd_count` exceeds 2^EVT_W is rejected. `cmd_err` pulses for one cycle on the edge after the request, `busy` stays low and no permission changes. A sum equal to 2^EVT_W is accepted.
- R3: A command whose `cmd_act` is neither 2'b01 (allow) nor 2'b10 (deny) is rejected in the same way as in R2.
- R4: When the first accepted command is an allow, events base..base+count-1 become permitted and every other event becomes denied.
- R5: When the first accepted command is a deny, events base..base+count-1 become denied and every other event stays permitted.
- R6: A command accepted after the first changes only events base..base+count-1. An allow sets their bits and a deny clears them.
- R7: A lookup of event 0 (software increment) always returns `lk_ok`=1.
- R8: A lookup accepted on an edge returns `lk_done`=1 for one cycle, two edges later. `lk_ok`=1 means the event's bit is set.
- R9: Once configured, bit i (0..31) of `cap_word` equals `cap_raw[i]` AND the permission of event 32*`cap_sel`+i. The result appears with a one-cycle `cap_done` pulse three edges after acceptance.
- R10: Once configured, bit 32+i of `cap_word` equals `cap_raw[32+i]` AND the permission of event HI_OFS+32*`cap_sel`+i, when HI_OFS+32*`cap_sel`+32 is not above 2^EVT_W. Otherwise the bit is 0.
- R11: When `cap_sel`=1 and `ver_new`=1, bit STALL_BIT (default 31) of `cap_word` is 0, whether or not the filter is configured.
- R12: An accepted command holds `busy` high for 2^EVT_W/32 fill cycles (first command only) plus 2 cycles per 32-bit word its range touches. Any request presented while `busy` is high is ignored. When requests arrive together, a command wins over a capability request, which wins over a lookup.
- R13: A synchronous reset (`rst`=1) returns the filter to the unconfigured state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_vld | input | 1 | Range command request |
| cmd_base | input | EVT_W+1 | First event of the range |
| cmd_count | input | EVT_W+1 | Number of events in the range |
| cmd_act | input | 2 | 2'b01 allow, 2'b10 deny |
| cmd_err | output | 1 | One-cycle pulse: command rejected |
| lk_vld | input | 1 | Lookup request |
| lk_evt | input | EVT_W | Event number to look up |
| lk_done | output | 1 | One-cycle pulse: lookup result valid |
| lk_ok | output | 1 | Event permitted |
| cap_vld | input | 1 | Capability masking request |
| cap_sel | input | 1 | 0: word for events 0..31, 1: word for events 32..63 |
| cap_raw | input | 64 | Unmasked capability value |
| ver_new | input | 1 | Newer architecture version: hide the stall-slot event |
| cap_done | output | 1 | One-cycle pulse: capability result valid |
| cap_word | output | 64 | Masked capability value |
| busy | output | 1 | Engine working; new requests ignored |

## Verification
On every cycle, assertions check these rules: a rejected command leaves the engine idle, result pulses last one cycle, event 0 and unconfigured lookups always pass, the stall-slot bit is hidden, an accepted request raises `busy`, and the configured flag stays fixed during work. Only the bench scenarios can show how the first command's action sets the default, that a later range leaves its neighbours untouched, the exact edges of a range, the zeroing of a high region that lies outside the store, the busy cycle counts, and that a lookup poked while busy is dropped. The bench compares each of these against a behavioural bit-array model.

// File: rtl/evt_permit_pkg.sv
package evt_permit_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_RD,
    ST_WR,
    ST_LOOK,
    ST_CAPL,
    ST_CAPH
  } fsm_t;

  localparam logic [1:0] ACT_ALLOW = 2'b01;
  localparam logic [1:0] ACT_DENY  = 2'b10;
  localparam int         WORD_BITS = 32;
endpackage

// File: rtl/evt_bit_ram.sv
module evt_bit_ram #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // single port, read-before-write, registered read data
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/evt_range_mask.sv
module evt_range_mask #(
  parameter int AW    = 5,
  parameter int CNT_W = 11
) (
  input  logic [AW-1:0]    word,
  input  logic [CNT_W-1:0] lo,
  input  logic [CNT_W-1:0] hi,
  output logic [31:0]      mask
);
  // one comparator pair per bit of the word: lo <= position < hi
  for (genvar i = 0; i < 32; i++) begin : g_bit
    localparam logic [4:0] IB = 5'(i);
    logic [CNT_W-1:0] pos;
    assign pos     = {1'b0, word, IB};
    assign mask[i] = (pos >= lo) && (pos < hi);
  end
endmodule

// File: rtl/evt_cap_merge.sv
module evt_cap_merge #(
  parameter int STALL_BIT = 31
) (
  input  logic [63:0] raw,
  input  logic        sel,
  input  logic        ver,
  input  logic        cfg,
  input  logic [31:0] lo,
  input  logic [31:0] hi,
  input  logic        hi_ok,
  output logic [63:0] result
);
  logic [63:0] trimmed;

  always_comb begin
    trimmed = raw;
    if (sel && ver) trimmed[STALL_BIT] = 1'b0;
    if (cfg) result = trimmed & {(hi_ok ? hi : 32'h0), lo};
    else     result = trimmed;
  end
endmodule

// File: rtl/evt_permit_filter.sv
module evt_permit_filter
  import evt_permit_pkg::*;
#(
  parameter int EVT_W     = 10,
  parameter int HI_OFS    = 16384,
  parameter int STALL_BIT = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_vld,
  input  logic [EVT_W:0]   cmd_base,
  input  logic [EVT_W:0]   cmd_count,
  input  logic [1:0]       cmd_act,
  output logic             cmd_err,
  input  logic             lk_vld,
  input  logic [EVT_W-1:0] lk_evt,
  output logic             lk_done,
  output logic             lk_ok,
  input  logic             cap_vld,
  input  logic             cap_sel,
  input  logic [63:0]      cap_raw,
  input  logic             ver_new,
  output logic             cap_done,
  output logic [63:0]      cap_word,
  output logic             busy
);
  localparam int CNT_W   = EVT_W + 1;
  localparam int NUM_EVT = 1 << EVT_W;
  localparam int NW      = NUM_EVT / WORD_BITS;
  localparam int AW      = EVT_W - 5;
  localparam bit HI_OK0  = (HI_OFS + 32) <= NUM_EVT;
  localparam bit HI_OK1  = (HI_OFS + 64) <= NUM_EVT;
  localparam logic [AW-1:0] HI_A0 = HI_OK0 ? AW'(HI_OFS / 32) : '0;
  localparam logic [AW-1:0] HI_A1 = HI_OK1 ? AW'(HI_OFS / 32 + 1) : '0;

  fsm_t             state;
  logic             cfg;
  logic             allow_q;
  logic [CNT_W-1:0] cur;
  logic [CNT_W-1:0] end_q;
  logic [AW-1:0]    fill_idx;
  logic [4:0]       lk_bit;
  logic             lk_sw;
  logic             cap_sel_q;
  logic             ver_q;
  logic [63:0]      raw_q;
  logic [31:0]      lo_q;

  logic             ram_we;
  logic [AW-1:0]    ram_addr;
  logic [31:0]      ram_wdata;
  logic [31:0]      ram_rdata;
  logic [31:0]      rng_mask;
  logic [63:0]      merged;

  logic [AW-1:0]    cur_word;
  logic [AW:0]      word_inc;
  logic [CNT_W-1:0] nxt;
  logic [CNT_W:0]   cmd_sum;
  logic             cmd_bad;

  assign cur_word = cur[EVT_W-1:5];
  assign word_inc = {1'b0, cur_word} + (AW+1)'(1);
  assign nxt      = {word_inc, 5'b0};
  assign cmd_sum  = {1'b0, cmd_base} + {1'b0, cmd_count};
  assign cmd_bad  = (cmd_sum > (CNT_W+1)'(NUM_EVT)) ||
                    ((cmd_act != ACT_ALLOW) && (cmd_act != ACT_DENY));
  assign busy     = (state != ST_IDLE);

  evt_bit_ram #(.AW(AW), .DW(32)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  evt_range_mask #(.AW(AW), .CNT_W(CNT_W)) u_mask (
    .word (cur_word),
    .lo   (cur),
    .hi   (end_q),
    .mask (rng_mask)
  );

  evt_cap_merge #(.STALL_BIT(STALL_BIT)) u_merge (
    .raw    (raw_q),
    .sel    (cap_sel_q),
    .ver    (ver_q),
    .cfg    (cfg),
    .lo     (lo_q),
    .hi     (ram_rdata),
    .hi_ok  (cap_sel_q ? HI_OK1 : HI_OK0),
    .result (merged)
  );

  // RAM port steering
  always_comb begin
    ram_we    = 1'b0;
    ram_addr  = '0;
    ram_wdata = '0;
    case (state)
      ST_IDLE: begin
        if (!cmd_vld) begin
          if (cap_vld)     ram_addr = cap_sel ? AW'(1) : AW'(0);
          else if (lk_vld) ram_addr = lk_evt[EVT_W-1:5];
        end
      end
      ST_FILL: begin
        ram_we    = 1'b1;
        ram_addr  = fill_idx;
        ram_wdata = allow_q ? 32'h0 : 32'hFFFF_FFFF;
      end
      ST_RD: ram_addr = cur_word;
      ST_WR: begin
        ram_we    = 1'b1;
        ram_addr  = cur_word;
        ram_wdata = allow_q ? (ram_rdata | rng_mask) : (ram_rdata & ~rng_mask);
      end
      ST_CAPL: ram_addr = cap_sel_q ? HI_A1 : HI_A0;
      default: ram_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cfg       <= 1'b0;
      allow_q   <= 1'b0;
      cur       <= '0;
      end_q     <= '0;
      fill_idx  <= '0;
      lk_bit    <= '0;
      lk_sw     <= 1'b0;
      cap_sel_q <= 1'b0;
      ver_q     <= 1'b0;
      raw_q     <= '0;
      lo_q      <= '0;
      cmd_err   <= 1'b0;
      lk_done   <= 1'b0;
      lk_ok     <= 1'b0;
      cap_done  <= 1'b0;
      cap_word  <= '0;
    end else begin
      cmd_err  <= 1'b0;
      lk_done  <= 1'b0;
      cap_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_vld) begin
            if (cmd_bad) begin
              cmd_err <= 1'b1;
            end else begin
              allow_q <= (cmd_act == ACT_ALLOW);
              cur     <= cmd_base;
              end_q   <= cmd_sum[CNT_W-1:0];
              if (!cfg) begin
                cfg      <= 1'b1;
                fill_idx <= '0;
                state    <= ST_FILL;
              end else if (cmd_count != '0) begin
                state <= ST_RD;
              end
            end
          end else if (cap_vld) begin
            cap_sel_q <= cap_sel;
            ver_q     <= ver_new;
            raw_q     <= cap_raw;
            state     <= ST_CAPL;
          end else if (lk_vld) begin
            lk_bit <= lk_evt[4:0];
            lk_sw  <= (lk_evt == '0);
            state  <= ST_LOOK;
          end
        end
        ST_FILL: begin
          fill_idx <= fill_idx + AW'(1);
          if (fill_idx == AW'(NW - 1))
            state <= (cur < end_q) ? ST_RD : ST_IDLE;
        end
        ST_RD: state <= ST_WR;
        ST_WR: begin
          cur   <= nxt;
          state <= (nxt >= end_q) ? ST_IDLE : ST_RD;
        end
        ST_LOOK: begin
          lk_done <= 1'b1;
          lk_ok   <= !cfg || lk_sw || ram_rdata[lk_bit];
          state   <= ST_IDLE;
        end
        ST_CAPL: begin
          lo_q  <= ram_rdata;
          state <= ST_CAPH;
        end
        ST_CAPH: begin
          cap_done <= 1'b1;
          cap_word <= merged;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2 R3
  reject_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> (!busy && $past(cmd_vld)));

  // R8
  lk_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    lk_done |=> !lk_done);

  // R9
  cap_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cap_done |=> !cap_done);

  // R7
  swinc_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_done && lk_sw) |-> lk_ok);

  // R1
  unconf_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_done && !cfg) |-> lk_ok);

  // R11
  stall_hidden_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_done && cap_sel_q && ver_q) |-> !cap_word[STALL_BIT]);

  // R12
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !cmd_vld && (lk_vld || cap_vld)) |=> busy);

  // R12
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (cfg == $past(cfg)));
endmodule

// File: tb/evt_permit_filter_test.sv
`timescale 1ns/1ps
module evt_permit_filter_test;
  localparam int EVT_W  = 10;
  localparam int NUM    = 1 << EVT_W;
  localparam int HI_OFS = 992;

  logic             clk = 1'b0;
  logic             rst;
  logic             cmd_vld;
  logic [EVT_W:0]   cmd_base;
  logic [EVT_W:0]   cmd_count;
  logic [1:0]       cmd_act;
  logic             cmd_err;
  logic             lk_vld;
  logic [EVT_W-1:0] lk_evt;
  logic             lk_done;
  logic             lk_ok;
  logic             cap_vld;
  logic             cap_sel;
  logic [63:0]      cap_raw;
  logic             ver_new;
  logic             cap_done;
  logic [63:0]      cap_word;
  logic             busy;

  always #2.5 clk = ~clk;

  evt_permit_filter #(.EVT_W(EVT_W), .HI_OFS(HI_OFS), .STALL_BIT(31)) uut (
    .clk(clk), .rst(rst),
    .cmd_vld(cmd_vld), .cmd_base(cmd_base), .cmd_count(cmd_count),
    .cmd_act(cmd_act), .cmd_err(cmd_err),
    .lk_vld(lk_vld), .lk_evt(lk_evt), .lk_done(lk_done), .lk_ok(lk_ok),
    .cap_vld(cap_vld), .cap_sel(cap_sel), .cap_raw(cap_raw),
    .ver_new(ver_new), .cap_done(cap_done), .cap_word(cap_word),
    .busy(busy)
  );

  int checks = 0;
  int errors = 0;
  bit mbits [NUM];
  bit mcfg;
  int lk_seen = 0;

  // per-clock monitor
  always @(negedge clk) begin
    if (lk_done) lk_seen++;
    if (!rst && lk_done && cap_done) begin
      checks++; errors++;
      $display("FAIL R12 two result pulses together actual=11 expected=01");
    end
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit look_exp(int ev);
    return !mcfg || ev == 0 || mbits[ev];
  endfunction

  function automatic logic [63:0] cap_exp(bit sel, logic [63:0] raw, bit ver);
    logic [63:0] r;
    int base;
    r    = raw;
    base = 32 * int'(sel);
    if (sel && ver) r[31] = 1'b0;
    if (!mcfg) return r;
    for (int i = 0; i < 32; i++) begin
      r[i] = r[i] & mbits[base + i];
      if (HI_OFS + base + 32 <= NUM) r[32+i] = r[32+i] & mbits[HI_OFS + base + i];
      else                           r[32+i] = 1'b0;
    end
    return r;
  endfunction

  task automatic model_cmd(int base, int cnt, bit allow);
    if (!mcfg) begin
      for (int i = 0; i < NUM; i++) mbits[i] = !allow;
      mcfg = 1'b1;
    end
    for (int i = base; i < base + cnt; i++) mbits[i] = allow;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cmd_vld = 0; lk_vld = 0; cap_vld = 0;
    cmd_base = '0; cmd_count = '0; cmd_act = 2'b00;
    lk_evt = '0; cap_sel = 0; cap_raw = '0; ver_new = 0;
    repeat (3) @(negedge clk);
    rst  = 1'b0;
    mcfg = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_lookup(int ev, string tag);
    bit e;
    e = look_exp(ev);
    @(negedge clk); lk_vld = 1'b1; lk_evt = EVT_W'(ev);
    @(negedge clk); lk_vld = 1'b0;
    @(negedge clk);
    chk(lk_done && (lk_ok == e), tag, {62'h0, lk_done, lk_ok}, {62'h0, 1'b1, e});
  endtask

  task automatic do_cap(bit sel, logic [63:0] raw, bit ver, string tag);
    logic [63:0] e;
    e = cap_exp(sel, raw, ver);
    @(negedge clk); cap_vld = 1'b1; cap_sel = sel; cap_raw = raw; ver_new = ver;
    @(negedge clk); cap_vld = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(cap_done && (cap_word == e), tag, cap_word, e);
  endtask

  // exp_busy < 0 skips the busy length check; poke sends a lookup while busy
  task automatic do_cmd(int base, int cnt, logic [1:0] act, bit exp_err,
                        int exp_busy, bit poke, string tag);
    int n;
    int seen0;
    @(negedge clk);
    cmd_vld = 1'b1; cmd_base = (EVT_W+1)'(base); cmd_count = (EVT_W+1)'(cnt); cmd_act = act;
    @(negedge clk); cmd_vld = 1'b0;
    if (exp_err) begin
      chk(cmd_err && !busy, tag, {62'h0, cmd_err, busy}, 64'h2);
    end else begin
      chk(!cmd_err, tag, {63'h0, cmd_err}, 64'h0);
      seen0 = lk_seen;
      n = 0;
      while (busy) begin
        n++;
        if (poke && n == 1) begin lk_vld = 1'b1; lk_evt = EVT_W'(500); end
        if (n == 2) lk_vld = 1'b0;
        @(negedge clk);
      end
      lk_vld = 1'b0;
      if (exp_busy >= 0) chk(n == exp_busy, tag, 64'(n), 64'(exp_busy));
      if (poke) begin
        repeat (3) @(negedge clk);
        chk(lk_seen == seen0, "R12 lookup while busy ignored",
            64'(lk_seen - seen0), 64'h0);
      end
      model_cmd(base, cnt, act == 2'b01);
    end
  endtask

  initial begin
    #(5ns * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // reset state
    chk(!busy && !lk_done && !cap_done && !cmd_err, "R13 reset outputs idle",
        {60'h0, busy, lk_done, cap_done, cmd_err}, 64'h0);

    // unconfigured behaviour
    do_lookup(5,   "R1 unconfigured lookup 5");
    do_lookup(700, "R1 unconfigured lookup 700");
    do_cap(1'b0, 64'hDEAD_BEEF_0123_4567, 1'b0, "R1 unconfigured cap word0");
    do_cap(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R11 stall bit hidden unconfigured");

    // rejections
    do_cmd(1000, 25, 2'b01, 1'b1, -1, 1'b0, "R2 range past end rejected");
    do_cmd(3, 5, 2'b11, 1'b1, -1, 1'b0, "R3 bad action 11 rejected");
    do_cmd(3, 5, 2'b00, 1'b1, -1, 1'b0, "R3 bad action 00 rejected");
    do_lookup(700, "R2 rejection left filter unconfigured");

    // first command allow 3..7: fill 32 words + one word RMW
    do_cmd(3, 5, 2'b01, 1'b0, 34, 1'b0, "R12 first allow busy cycles");
    do_lookup(2, "R4 outside first allow denied");
    do_lookup(3, "R4 range start allowed");
    do_lookup(7, "R4 range end allowed");
    do_lookup(8, "R4 just past range denied");
    do_lookup(600, "R4 far event denied");

    // later commands
    do_cmd(5, 40, 2'b10, 1'b0, 4, 1'b0, "R12 deny two words busy");
    do_lookup(4, "R6 below deny range kept");
    do_lookup(5, "R6 deny range start cleared");
    do_cmd(30, 40, 2'b01, 1'b0, 6, 1'b0, "R12 allow three words busy");
    do_lookup(29, "R6 below allow range unchanged");
    do_lookup(30, "R6 allow range start set");
    do_lookup(69, "R6 allow range end set");
    do_lookup(70, "R6 past allow range unchanged");
    do_lookup(0, "R7 software increment always allowed");

    // exact-end boundary accepted
    do_cmd(1000, 24, 2'b01, 1'b0, 2, 1'b0, "R2 sum equal to size accepted");
    do_lookup(1023, "R2 last event allowed");
    do_lookup(999, "R6 before boundary range unchanged");

    // capability masking
    do_cap(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R9 R10 word0 masked");
    do_cap(1'b0, 64'h5A5A_5A5A_A5A5_A5A5, 1'b0, "R9 R10 word0 pattern masked");
    do_cap(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R10 R11 word1 high region outside zero");
    do_cap(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R9 word1 stall kept when old version");

    // whole-range allow with a lookup poked while busy
    do_cmd(0, 1024, 2'b01, 1'b0, 64, 1'b1, "R12 full range busy cycles");
    do_lookup(500, "R6 full allow reaches 500");
    do_cap(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R9 R10 word0 all allowed");

    // reset returns to unconfigured, then first deny
    do_reset();
    do_lookup(600, "R13 reset restores unconfigured");
    do_cmd(10, 1, 2'b10, 1'b0, 34, 1'b0, "R12 first deny busy cycles");
    do_lookup(9,  "R5 outside first deny allowed");
    do_lookup(10, "R5 deny range denied");
    do_lookup(11, "R5 after deny range allowed");
    do_cap(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R5 R9 word0 after first deny");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule